// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

An eight-pin general-purpose I/O port controlled through a simple 32-bit, word-addressed register bus. Its data register is seen through a window of 256 word locations. Byte address bits 9:2 of each access act as a per-pin mask, so software can set or clear any chosen group of pins with a single write, without a read-modify-write sequence. The same mask selects which pins a read returns.

A direction register decides, pin by pin, whether the pin is driven from the data register or sampled from the pad input. Inputs pass through a two-stage synchroniser before they are read or checked for interrupts. Each pin can raise an interrupt on a level or on an edge. Edge events stay latched until software clears them. A mode-select register is brought out for the surrounding multiplexing logic. Read-only identification words complete the map.

Register offsets (byte addresses): data window 0x000-0x3FC, direction 0x400, trigger type 0x404, dual-edge 0x408, polarity 0x40C, interrupt enable 0x410, raw status 0x414, masked status 0x418, clear 0x41C, mode select 0x420, peripheral ID 0xFE0-0xFEC, cell ID 0xFF0-0xFFC. A read from an unmapped or write-only location returns zero.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset all registers are zero. pinOe, pinOut and irq are 0, and the direction register reads 0.
- R2: A write in the data window updates only the data bits whose mask bit (address bit 2+i for pin i) is 1. The other bits keep their value. A write with mask 0 changes nothing.
- R3: A read in the data window returns the pin state in the bits whose mask bit is 1. All other bits, including bits 31:8, read as 0.
- R4: For an output pin, the pin state is the data register bit. For an input pin, it is pinIn after the two-stage synchroniser, which is visible from the second rising edge after pinIn changes.
- R5: pinOe equals the direction register (1 = output). The direction register is written at 0x400 and reads back what was written.
- R6: A pin whose trigger-type bit (0x404) is 1 is level-sensitive. Its raw status is 1 while the synchronised input equals its polarity bit (0x40C; 1 = high). Writing the clear register does not remove a level that is still present.
- R7: An edge on an edge-sensitive pin (trigger-type 0) sets its raw status bit, which stays set until a 1 is written to that bit of the clear register (0x41C).
- R8: When the dual-edge bit (0x408) of an edge-sensitive pin is 1, both rising and falling edges set its status, and the polarity bit is ignored.
- R9: For a single-edge pin, polarity 1 selects the rising edge and polarity 0 selects the falling edge.
- R10: Masked status (0x418) equals raw status (0x414) AND enable (0x410). irq is the OR of the masked status bits.
- R11: The cell ID words at 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1. The peripheral ID words at 0xFE0-0xFEC read the bytes of the PERIPH_ID parameter, least significant byte first.
- R12: Writes to raw status, masked status and the ID words have no effect.
- R13: The mode-select register (0x420) reads back what was written and drives modeSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address; bits 1:0 ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid combinationally while a read is selected |
| pinIn | input | 8 | Asynchronous pin inputs |
| pinOut | output | 8 | Data register driven to the pads |
| pinOe | output | 8 | Per-pin output enable |
| modeSel | output | 8 | Mode-select register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted data or direction bit shows on pinOut or pinOe on the cycle after the write that caused it. A mask-decoding error shows at the latest on the next masked read-back. A wrong synchroniser depth or edge-latch state shows on irq within two to three cycles of a pinIn change, and also on the raw and masked status reads. The bench keeps a cycle-level model of every register and compares pinOut, pinOe, irq and every read word on each clock, so a divergence is reported on the cycle it first appears.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int MASK_W = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT,
    RD_ENABLE, RD_RAW, RD_MASKED, RD_MODE, RD_PID, RD_CID
  } rdSel_e;

  typedef struct packed {
    logic              wrData;
    logic              wrDir;
    logic              wrSense;
    logic              wrBoth;
    logic              wrEvent;
    logic              wrEnable;
    logic              wrClear;
    logic              wrMode;
    logic [MASK_W-1:0] mask;
    logic [1:0]        idIdx;
    rdSel_e            rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int WORD_W = MASK_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [WORD_W-1:0] wordIdx,
  output ctrlStrobe_t       strb
);
  localparam logic [WORD_W-1:0] W_DIR    = WORD_W'(1 << MASK_W);
  localparam logic [WORD_W-1:0] W_SENSE  = W_DIR + 1;
  localparam logic [WORD_W-1:0] W_BOTH   = W_DIR + 2;
  localparam logic [WORD_W-1:0] W_EVENT  = W_DIR + 3;
  localparam logic [WORD_W-1:0] W_ENABLE = W_DIR + 4;
  localparam logic [WORD_W-1:0] W_RAW    = W_DIR + 5;
  localparam logic [WORD_W-1:0] W_MASKED = W_DIR + 6;
  localparam logic [WORD_W-1:0] W_CLEAR  = W_DIR + 7;
  localparam logic [WORD_W-1:0] W_MODE   = W_DIR + 8;
  localparam logic [WORD_W-3:0] GRP_CID  = '1;
  localparam logic [WORD_W-3:0] GRP_PID  = GRP_CID - 1'b1;

  logic wrEn, rdEn, inDataWin;
  assign wrEn      = busSel & busWr;
  assign rdEn      = busSel & ~busWr;
  assign inDataWin = (wordIdx[WORD_W-1:MASK_W] == '0);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    strb.mask  = wordIdx[MASK_W-1:0];
    strb.idIdx = wordIdx[1:0];
    if (inDataWin) begin
      strb.wrData = wrEn;
      if (rdEn) strb.rdSel = RD_DATA;
    end else if (wordIdx[WORD_W-1:2] == GRP_CID) begin
      if (rdEn) strb.rdSel = RD_CID;
    end else if (wordIdx[WORD_W-1:2] == GRP_PID) begin
      if (rdEn) strb.rdSel = RD_PID;
    end else begin
      unique case (wordIdx)
        W_DIR:    begin strb.wrDir    = wrEn; if (rdEn) strb.rdSel = RD_DIR;    end
        W_SENSE:  begin strb.wrSense  = wrEn; if (rdEn) strb.rdSel = RD_SENSE;  end
        W_BOTH:   begin strb.wrBoth   = wrEn; if (rdEn) strb.rdSel = RD_BOTH;   end
        W_EVENT:  begin strb.wrEvent  = wrEn; if (rdEn) strb.rdSel = RD_EVENT;  end
        W_ENABLE: begin strb.wrEnable = wrEn; if (rdEn) strb.rdSel = RD_ENABLE; end
        W_RAW:    begin if (rdEn) strb.rdSel = RD_RAW;    end
        W_MASKED: begin if (rdEn) strb.rdSel = RD_MASKED; end
        W_CLEAR:  begin strb.wrClear  = wrEn; end
        W_MODE:   begin strb.wrMode   = wrEn; if (rdEn) strb.rdSel = RD_MODE;   end
        default:  ;
      endcase
    end
  end

  // At most one register write strobe per access; read-only words raise none.
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.wrSense, strb.wrBoth,
              strb.wrEvent, strb.wrEnable, strb.wrClear, strb.wrMode}));

  assert_no_write_on_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr) |-> !(strb.wrData || strb.wrDir || strb.wrClear || strb.wrMode));
endmodule

// File: rtl/gpio_mask_dp.sv
module gpio_mask_dp
  import gpio_mask_pkg::*;
#(
  parameter int          PORT_W    = MASK_W,
  parameter int          SYNC_N    = 2,
  parameter logic [31:0] PERIPH_ID = 32'h0041_2A5C,
  parameter logic [31:0] CELL_ID   = 32'hB105_F00D
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pinIn,
  output logic [31:0]       rdata,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic [PORT_W-1:0] modeSel,
  output logic              irq
);
  logic [PORT_W-1:0] dataReg, dirReg, senseReg, bothReg, eventReg, enableReg, modeReg;
  logic [PORT_W-1:0] edgeLatch, edgeHit, levelHit, rawStat, maskedStat, pinState;
  logic [SYNC_N:0][PORT_W-1:0] syncChain;
  logic [PORT_W-1:0] inSync, inPrev, maskBits;

  assign maskBits = strb.mask[PORT_W-1:0];
  assign inSync   = syncChain[SYNC_N-1];
  assign inPrev   = syncChain[SYNC_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0; dirReg <= '0; senseReg <= '0; bothReg <= '0;
      eventReg <= '0; enableReg <= '0; modeReg <= '0;
      syncChain <= '0; edgeLatch <= '0;
    end else begin
      syncChain <= {syncChain[SYNC_N-1:0], pinIn};
      if (strb.wrData)   dataReg   <= (dataReg & ~maskBits) | (wdata & maskBits);
      if (strb.wrDir)    dirReg    <= wdata;
      if (strb.wrSense)  senseReg  <= wdata;
      if (strb.wrBoth)   bothReg   <= wdata;
      if (strb.wrEvent)  eventReg  <= wdata;
      if (strb.wrEnable) enableReg <= wdata;
      if (strb.wrMode)   modeReg   <= wdata;
      // A new edge in the same cycle as a clear wins.
      edgeLatch <= (edgeLatch & ~(strb.wrClear ? wdata : '0)) | (edgeHit & ~senseReg);
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic rise, fall;
    assign rise        = inSync[i] & ~inPrev[i];
    assign fall        = ~inSync[i] & inPrev[i];
    assign edgeHit[i]  = bothReg[i] ? (rise | fall) : (eventReg[i] ? rise : fall);
    assign levelHit[i] = eventReg[i] ? inSync[i] : ~inSync[i];
    assign rawStat[i]  = senseReg[i] ? levelHit[i] : edgeLatch[i];
    assign pinState[i] = dirReg[i] ? dataReg[i] : inSync[i];
  end

  assign maskedStat = rawStat & enableReg;
  assign irq        = |maskedStat;
  assign pinOut     = dataReg;
  assign pinOe      = dirReg;
  assign modeSel    = modeReg;

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      RD_DATA:   rdata[PORT_W-1:0] = pinState & maskBits;
      RD_DIR:    rdata[PORT_W-1:0] = dirReg;
      RD_SENSE:  rdata[PORT_W-1:0] = senseReg;
      RD_BOTH:   rdata[PORT_W-1:0] = bothReg;
      RD_EVENT:  rdata[PORT_W-1:0] = eventReg;
      RD_ENABLE: rdata[PORT_W-1:0] = enableReg;
      RD_RAW:    rdata[PORT_W-1:0] = rawStat;
      RD_MASKED: rdata[PORT_W-1:0] = maskedStat;
      RD_MODE:   rdata[PORT_W-1:0] = modeReg;
      RD_PID:    rdata[7:0]        = PERIPH_ID[strb.idIdx*8 +: 8];
      RD_CID:    rdata[7:0]        = CELL_ID[strb.idIdx*8 +: 8];
      default:   ;
    endcase
  end

  assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> ((pinOut ^ $past(pinOut)) & ~$past(maskBits)) == '0);

  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> pinOe == $past(wdata));

  assert_clear_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClear |=> (edgeLatch & $past(wdata & ~(edgeHit & ~senseReg))) == '0);

  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (enableReg != '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter logic [31:0] PERIPH_ID = 32'h0041_2A5C,
  parameter logic [31:0] CELL_ID   = 32'hB105_F00D,
  parameter int          SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [MASK_W+3:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [MASK_W-1:0] pinIn,
  output logic [MASK_W-1:0] pinOut,
  output logic [MASK_W-1:0] pinOe,
  output logic [MASK_W-1:0] modeSel,
  output logic              irq
);
  localparam int ADDR_W = MASK_W + 4;
  localparam int WORD_W = ADDR_W - 2;

  ctrlStrobe_t strb;

  gpio_mask_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .wordIdx(busAddr[ADDR_W-1:2]), .strb(strb)
  );

  gpio_mask_dp #(
    .PORT_W(MASK_W), .SYNC_N(SYNC_N), .PERIPH_ID(PERIPH_ID), .CELL_ID(CELL_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata[MASK_W-1:0]),
    .pinIn(pinIn), .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
    .modeSel(modeSel), .irq(irq)
  );
endmodule

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PID = 32'h0041_2A5C;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [7:0] pinIn = '0, pinOut, pinOe, modeSel;
  logic irq;

  int testCount = 0, failCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .modeSel(modeSel), .irq(irq)
  );

  // Behavioural reference model, updated on every rising edge.
  logic [7:0] mData, mDir, mSense, mBoth, mEv, mEn, mMode, mLatch;
  logic [7:0] sq [0:2];

  function automatic logic [7:0] mRaw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (mSense[i]) r[i] = (sq[1][i] == mEv[i]);
      else           r[i] = mLatch[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] mRead(input logic [11:0] a);
    int w;
    logic [7:0] st;
    w = int'(a >> 2);
    st = (mDir & mData) | (~mDir & sq[1]);
    if (w < 256) return {24'h0, st & w[7:0]};
    case (w)
      'h100: return {24'h0, mDir};
      'h101: return {24'h0, mSense};
      'h102: return {24'h0, mBoth};
      'h103: return {24'h0, mEv};
      'h104: return {24'h0, mEn};
      'h105: return {24'h0, mRaw()};
      'h106: return {24'h0, mRaw() & mEn};
      'h108: return {24'h0, mMode};
      'h3F8, 'h3F9, 'h3FA, 'h3FB: return {24'h0, PID[(w - 'h3F8) * 8 +: 8]};
      'h3FC: return 32'h0D;
      'h3FD: return 32'hF0;
      'h3FE: return 32'h05;
      'h3FF: return 32'hB1;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mData = 0; mDir = 0; mSense = 0; mBoth = 0; mEv = 0; mEn = 0; mMode = 0; mLatch = 0;
      sq[0] = 0; sq[1] = 0; sq[2] = 0;
    end else begin
      logic [7:0] clr, hit;
      clr = 0;
      for (int i = 0; i < 8; i++) begin
        bit r, f;
        r = sq[1][i] && !sq[2][i];
        f = !sq[1][i] && sq[2][i];
        hit[i] = !mSense[i] && (mBoth[i] ? (r || f) : (mEv[i] ? r : f));
      end
      if (busSel && busWr) begin
        int w;
        w = int'(busAddr >> 2);
        if (w < 256) mData = (mData & ~w[7:0]) | (busWdata[7:0] & w[7:0]);
        case (w)
          'h100: mDir = busWdata[7:0];
          'h101: mSense = busWdata[7:0];
          'h102: mBoth = busWdata[7:0];
          'h103: mEv = busWdata[7:0];
          'h104: mEn = busWdata[7:0];
          'h107: clr = busWdata[7:0];
          'h108: mMode = busWdata[7:0];
          default: ;
        endcase
      end
      mLatch = (mLatch & ~clr) | hit;
      sq[2] = sq[1]; sq[1] = sq[0]; sq[0] = pinIn;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Continuous comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      chk("R2 pinOut vs model", {24'h0, pinOut}, {24'h0, mData});
      chk("R5 pinOe vs model", {24'h0, pinOe}, {24'h0, mDir});
      chk("R10 irq vs model", {31'h0, irq}, {31'h0, |(mRaw() & mEn)});
      chk("R13 modeSel vs model", {24'h0, modeSel}, {24'h0, mMode});
      if (busSel && !busWr) chk("R3 read vs model", busRdata, mRead(busAddr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testCount++; failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 pinOe", {24'h0, pinOe}, 0);
    chk("R1 pinOut", {24'h0, pinOut}, 0);
    chk("R1 irq", {31'h0, irq}, 0);
    rd(12'h400, d); chk("R1 dir reads 0", d, 0);

    // R13 mode select
    wr(12'h420, 32'hA5); rd(12'h420, d); chk("R13 mode readback", d, 32'hA5);
    #2 chk("R13 modeSel", {24'h0, modeSel}, 32'hA5);

    // R5 direction
    wr(12'h400, 32'hFF); #2 chk("R5 pinOe all out", {24'h0, pinOe}, 32'hFF);
    rd(12'h400, d); chk("R5 dir readback", d, 32'hFF);

    // R2 masked writes
    wr(12'h03C, 32'hFF); #2 chk("R2 set low nibble", {24'h0, pinOut}, 32'h0F);
    wr(12'h00C, 32'h00); #2 chk("R2 clear bits 1:0", {24'h0, pinOut}, 32'h0C);
    wr(12'h000, 32'hFF); #2 chk("R2 zero mask no change", {24'h0, pinOut}, 32'h0C);

    // R3 masked reads
    rd(12'h3FC, d); chk("R3 full mask read", d, 32'h0C);
    rd(12'h010, d); chk("R3 mask 0x04 read", d, 32'h04);
    rd(12'h020, d); chk("R3 mask 0x08 read", d, 32'h08);
    wr(12'h3FC, 32'hFFFF_FFFF); rd(12'h3FC, d); chk("R3 upper bits zero", d, 32'hFF);

    // R4 input pins read synchronised input
    wr(12'h400, 32'h0F);
    setPins(8'hA0);
    rd(12'h3FC, d); chk("R4 mixed dir read", d, 32'hAF);

    // R11 identification words
    rd(12'hFF0, d); chk("R11 cell id 0", d, 32'h0D);
    rd(12'hFF4, d); chk("R11 cell id 1", d, 32'hF0);
    rd(12'hFF8, d); chk("R11 cell id 2", d, 32'h05);
    rd(12'hFFC, d); chk("R11 cell id 3", d, 32'hB1);
    rd(12'hFE0, d); chk("R11 periph id 0", d, 32'h5C);
    rd(12'hFEC, d); chk("R11 periph id 3", d, 32'h00);

    // R12 read-only locations ignore writes
    wr(12'hFF0, 32'h55); rd(12'hFF0, d); chk("R12 cell id unchanged", d, 32'h0D);
    wr(12'h400, 32'h00);
    setPins(8'h00);
    wr(12'h41C, 32'hFF);
    wr(12'h414, 32'hFF); rd(12'h414, d); chk("R12 raw unchanged", d, 32'h00);
    wr(12'h418, 32'hFF); rd(12'h418, d); chk("R12 masked unchanged", d, 32'h00);

    // R9 rising edge, R7 latch and clear
    wr(12'h40C, 32'h01); wr(12'h410, 32'h01);
    setPins(8'h01); #2 chk("R9 rising edge irq", {31'h0, irq}, 1);
    rd(12'h414, d); chk("R7 raw latched", d & 32'h01, 32'h01);
    rd(12'h418, d); chk("R10 masked status", d, 32'h01);
    wr(12'h41C, 32'h01); #2 chk("R7 clear drops irq", {31'h0, irq}, 0);
    // R9 falling edge with polarity 0
    wr(12'h40C, 32'h00);
    setPins(8'h00); #2 chk("R9 falling edge irq", {31'h0, irq}, 1);
    wr(12'h41C, 32'h01); #2 chk("R7 clear after fall", {31'h0, irq}, 0);
    // R8 both edges, polarity ignored
    wr(12'h408, 32'h01);
    setPins(8'h01); #2 chk("R8 rise with dual edge", {31'h0, irq}, 1);
    wr(12'h41C, 32'h01);
    setPins(8'h00); #2 chk("R8 fall with dual edge", {31'h0, irq}, 1);
    wr(12'h41C, 32'h01); #2 chk("R8 cleared", {31'h0, irq}, 0);

    // R6 level-sensitive high level
    wr(12'h404, 32'h06); wr(12'h40C, 32'h02); wr(12'h410, 32'h02);
    setPins(8'h06); #2 chk("R6 level high irq", {31'h0, irq}, 1);
    wr(12'h41C, 32'h02); #2 chk("R6 clear keeps level", {31'h0, irq}, 1);
    setPins(8'h00); #2 chk("R6 level gone", {31'h0, irq}, 0);

    // R10 raw without enable does not reach masked status
    rd(12'h414, d); chk("R10 raw low-level bit2", d & 32'h04, 32'h04);
    rd(12'h418, d); chk("R10 masked excludes bit2", d & 32'h04, 32'h00);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule